// File: doc/BRIEF.md
# Stripe Virtualization Reconfiguration Sequencer

This block lets a short chain of physical pipeline stripes run a virtual pipeline that is longer than the chain. Once started, it loads exactly one stripe per clock cycle. It reads a virtual stripe's configuration word from a configuration memory and writes it into the configuration latch of one physical stripe. It steps through the physical stripes as a ring. All other stripes keep computing while one is being loaded, and no host takes part in the loop.

When the virtual design is longer than the physical chain, loading a stripe evicts the virtual stripe that held it. In that same cycle the sequencer writes the evicted stripe's R0 register into a state memory, indexed by the evicted virtual stripe. When a virtual stripe comes back on a later pass, its saved R0 is read back and driven onto the restore bus together with its configuration. On the first pass the restore value comes from a host-supplied initial value, selected by virtual index, and the state memory is not read.

Both memories are synchronous, with one cycle of read latency. The sequencer has no back-pressure, because a step runs every cycle. For that reason there is no valid/ready handshake at any edge of the block. Control and status are plain level and pulse pins.

Top module: `vsr_sequencer`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and 1 <= `virt_count` <= MAX_VIRT. Otherwise it is ignored and no read or load follows. On acceptance, `virt_count` (nv) and `passes` are captured, and a `passes` value of 0 counts as 1.
- R2: Step k (counting from 0) loads virtual stripe k mod nv into physical stripe k mod NUM_PHYS. In the cycle the step is issued, `cfg_rd_en` is high with `cfg_rd_addr` = virtual index. In the next cycle, bit p of `stripe_cfg_en` is high and `stripe_cfg` equals the word read. Steps run back to back, one per cycle.
- R3: At most one bit of `stripe_cfg_en` is high in any cycle, and `r0_restore_en` always equals `stripe_cfg_en`.
- R4: Consecutive loads move the enable bit from stripe p to stripe (p+1) mod NUM_PHYS.
- R5: If nv > NUM_PHYS and k >= NUM_PHYS, `st_wr_en` is high in the load cycle of step k. In that case `st_wr_addr` = (k − NUM_PHYS) mod nv and `st_wr_data` = `r0_save[p*R0_W +: R0_W]` for the loaded stripe p. No state write happens at any other time.
- R6: For steps k < nv, and for every step when nv <= NUM_PHYS, `r0_restore` equals `init_r0` while `init_idx` shows the virtual index. `st_rd_en` stays low in all of these cases.
- R7: On later passes, `st_rd_en` is high with `st_rd_addr` = virtual index in the issue cycle. `r0_restore` then carries the R0 value last saved for that virtual stripe.
- R8: If a state read and a state write hit the same address in the same cycle (which happens when nv = NUM_PHYS+1), the restore value is the word being written.
- R9: A run has S = nv·max(passes,1) steps when nv > NUM_PHYS, and S = nv steps otherwise. If `start` is sampled at edge 0, `busy` is high in cycles 1..S+1. In cycle S+2, `done` is high for one cycle and `busy` is low.
- R10: During and after reset, `busy`, `done`, `cfg_rd_en`, `st_rd_en`, `st_wr_en` and `stripe_cfg_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run |
| virt_count | input | VC_W | Number of virtual stripes for the run |
| passes | input | PASS_W | Passes over the virtual design (0 means 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_rd_en | output | 1 | Configuration memory read enable |
| cfg_rd_addr | output | VA_W | Virtual stripe to read |
| cfg_rd_data | input | CFG_W | Configuration word, one cycle after the read |
| stripe_cfg | output | CFG_W | Configuration bus to all stripe latches |
| stripe_cfg_en | output | NUM_PHYS | One-hot latch enable |
| st_rd_en | output | 1 | State memory read enable |
| st_rd_addr | output | VA_W | Virtual stripe whose R0 is read |
| st_rd_data | input | R0_W | State word, one cycle after the read |
| st_wr_en | output | 1 | State memory write enable |
| st_wr_addr | output | VA_W | Evicted virtual stripe |
| st_wr_data | output | R0_W | Saved R0 value |
| init_idx | output | VA_W | Virtual index for the initial-value lookup |
| init_r0 | input | R0_W | Host-supplied initial R0 for `init_idx` |
| r0_save | input | NUM_PHYS*R0_W | R0 of every physical stripe, stripe p at bits p*R0_W |
| r0_restore | output | R0_W | R0 value to load |
| r0_restore_en | output | NUM_PHYS | One-hot R0 load enable |

## Verification
A wrong ring or virtual counter shows up at the latch enables one cycle after the faulty issue. It appears as a wrong stripe bit or as a configuration word that belongs to another virtual index. A wrong eviction index is silent when the write happens. It only becomes visible a full pass later, when that virtual stripe comes back and restores a value that was never saved for it, so the bench follows every saved R0 through to its restore. A missing forward for a same-cycle read and write appears as a stale restore on every step of a run with nv = NUM_PHYS+1. A pass or length counter that is off shows up as `done` arriving in the wrong cycle.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

  // Source of the value driven on the R0 restore bus
  typedef enum logic [1:0] {
    SRC_INIT  = 2'd0,
    SRC_STORE = 2'd1,
    SRC_FWD   = 2'd2
  } r0_src_e;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vsr_step_gen.sv
module vsr_step_gen
  import vsr_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int MAX_VIRT = 16,
  parameter int PASS_W   = 4,
  localparam int VA_W    = width_of(MAX_VIRT),
  localparam int VC_W    = width_of(MAX_VIRT + 1),
  localparam int PA_W    = width_of(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic [VC_W-1:0]   virt_count,
  input  logic [PASS_W-1:0] passes,
  output logic              iss_valid,
  output logic [VA_W-1:0]   iss_v,
  output logic [PA_W-1:0]   iss_p,
  output logic              iss_virt,
  output logic              iss_first,
  output logic              iss_save,
  output logic              iss_last,
  output logic [VC_W-1:0]   nv_o
);
  localparam int SEEN_W = width_of(NUM_PHYS + 1);

  logic              run_q, virt_q;
  logic [VA_W-1:0]   v_q;
  logic [PA_W-1:0]   p_q;
  logic [PASS_W-1:0] pass_q, npass_q;
  logic [VC_W-1:0]   nv_q;
  logic [SEEN_W-1:0] seen_q;
  logic              accept, v_end, p_end;

  assign accept = start && !busy && (virt_count != '0) &&
                  (virt_count <= VC_W'(MAX_VIRT));
  assign v_end  = (VC_W'(v_q) == nv_q - VC_W'(1));
  assign p_end  = (p_q == PA_W'(NUM_PHYS - 1));

  assign iss_valid = run_q;
  assign iss_v     = v_q;
  assign iss_p     = p_q;
  assign iss_virt  = virt_q;
  assign iss_first = (pass_q == '0);
  assign iss_save  = virt_q && (seen_q == SEEN_W'(NUM_PHYS));
  assign iss_last  = run_q && v_end && (!virt_q || pass_q == npass_q - PASS_W'(1));
  assign nv_o      = nv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      virt_q  <= 1'b0;
      v_q     <= '0;
      p_q     <= '0;
      pass_q  <= '0;
      npass_q <= '0;
      nv_q    <= '0;
      seen_q  <= '0;
    end else if (accept) begin
      run_q   <= 1'b1;
      v_q     <= '0;
      p_q     <= '0;
      pass_q  <= '0;
      seen_q  <= '0;
      nv_q    <= virt_count;
      npass_q <= (passes == '0) ? PASS_W'(1) : passes;
      virt_q  <= (virt_count > VC_W'(NUM_PHYS));
    end else if (run_q) begin
      if (iss_last) run_q <= 1'b0;
      p_q <= p_end ? '0 : p_q + PA_W'(1);
      if (v_end) begin
        v_q    <= '0;
        pass_q <= pass_q + PASS_W'(1);
      end else begin
        v_q <= v_q + VA_W'(1);
      end
      if (seen_q != SEEN_W'(NUM_PHYS)) seen_q <= seen_q + SEEN_W'(1);
    end
  end

  // R9: a run never issues beyond its captured pass count
  p_pass_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pass_q < npass_q));

endmodule

// File: rtl/vsr_apply.sv
module vsr_apply
  import vsr_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int MAX_VIRT = 16,
  parameter int R0_W     = 8,
  localparam int VA_W    = width_of(MAX_VIRT),
  localparam int VC_W    = width_of(MAX_VIRT + 1),
  localparam int PA_W    = width_of(NUM_PHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [VA_W-1:0]          iss_v,
  input  logic [PA_W-1:0]          iss_p,
  input  logic                     iss_virt,
  input  logic                     iss_first,
  input  logic                     iss_save,
  input  logic                     iss_last,
  input  logic [VC_W-1:0]          nv,
  input  logic                     st_rd_en,
  input  logic [R0_W-1:0]          st_rd_data,
  input  logic [R0_W-1:0]          init_r0,
  input  logic [NUM_PHYS*R0_W-1:0] r0_save,
  output logic [NUM_PHYS-1:0]      latch_en,
  output logic [R0_W-1:0]          r0_restore,
  output logic                     st_wr_en,
  output logic [VA_W-1:0]          st_wr_addr,
  output logic [R0_W-1:0]          st_wr_data,
  output logic [VA_W-1:0]          init_idx,
  output logic                     ap_valid,
  output logic                     done
);
  localparam int W1 = VC_W + 1;

  logic            ap_valid_q, ap_save_q, ap_last_q, done_q;
  logic [VA_W-1:0] ap_v_q;
  logic [PA_W-1:0] ap_p_q;
  r0_src_e         src_q, src_d;
  logic [R0_W-1:0] fwd_q;
  logic [W1-1:0]   ext_v, out_idx;
  logic            fwd_hit;

  // Evicted virtual stripe: (v - NUM_PHYS) mod nv, valid only when nv > NUM_PHYS
  assign ext_v   = W1'(ap_v_q);
  assign out_idx = (ext_v >= W1'(NUM_PHYS)) ? ext_v - W1'(NUM_PHYS)
                                            : ext_v + W1'(nv) - W1'(NUM_PHYS);

  assign st_wr_en   = ap_valid_q && ap_save_q;
  assign st_wr_addr = out_idx[VA_W-1:0];
  assign st_wr_data = r0_save[int'(ap_p_q)*R0_W +: R0_W];

  // Same-cycle read and write of one address: take the word being written
  assign fwd_hit = st_rd_en && st_wr_en && (st_wr_addr == iss_v);

  always_comb begin
    if (iss_first || !iss_virt) src_d = SRC_INIT;
    else if (fwd_hit)           src_d = SRC_FWD;
    else                        src_d = SRC_STORE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_valid_q <= 1'b0;
      ap_save_q  <= 1'b0;
      ap_last_q  <= 1'b0;
      done_q     <= 1'b0;
      ap_v_q     <= '0;
      ap_p_q     <= '0;
      src_q      <= SRC_INIT;
      fwd_q      <= '0;
    end else begin
      ap_valid_q <= iss_valid;
      ap_save_q  <= iss_save;
      ap_last_q  <= iss_last;
      ap_v_q     <= iss_v;
      ap_p_q     <= iss_p;
      src_q      <= src_d;
      fwd_q      <= st_wr_data;
      done_q     <= ap_valid_q && ap_last_q;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_STORE: r0_restore = st_rd_data;
      SRC_FWD:   r0_restore = fwd_q;
      default:   r0_restore = init_r0;
    endcase
  end

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_en
    assign latch_en[i] = ap_valid_q && (ap_p_q == PA_W'(i));
  end

  assign init_idx = ap_v_q;
  assign ap_valid = ap_valid_q;
  assign done     = done_q;

  p_onehot_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_en));

  p_save_with_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |-> $onehot(latch_en));

endmodule

// File: rtl/vsr_sequencer.sv
module vsr_sequencer
  import vsr_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int MAX_VIRT = 16,
  parameter int CFG_W    = 672,
  parameter int R0_W     = 8,
  parameter int PASS_W   = 4,
  localparam int VA_W    = width_of(MAX_VIRT),
  localparam int VC_W    = width_of(MAX_VIRT + 1),
  localparam int PA_W    = width_of(NUM_PHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [VC_W-1:0]          virt_count,
  input  logic [PASS_W-1:0]        passes,
  output logic                     busy,
  output logic                     done,
  output logic                     cfg_rd_en,
  output logic [VA_W-1:0]          cfg_rd_addr,
  input  logic [CFG_W-1:0]         cfg_rd_data,
  output logic [CFG_W-1:0]         stripe_cfg,
  output logic [NUM_PHYS-1:0]      stripe_cfg_en,
  output logic                     st_rd_en,
  output logic [VA_W-1:0]          st_rd_addr,
  input  logic [R0_W-1:0]          st_rd_data,
  output logic                     st_wr_en,
  output logic [VA_W-1:0]          st_wr_addr,
  output logic [R0_W-1:0]          st_wr_data,
  output logic [VA_W-1:0]          init_idx,
  input  logic [R0_W-1:0]          init_r0,
  input  logic [NUM_PHYS*R0_W-1:0] r0_save,
  output logic [R0_W-1:0]          r0_restore,
  output logic [NUM_PHYS-1:0]      r0_restore_en
);
  logic            iss_valid, iss_virt, iss_first, iss_save, iss_last, ap_valid;
  logic [VA_W-1:0] iss_v;
  logic [PA_W-1:0] iss_p;
  logic [VC_W-1:0] nv;
  logic [NUM_PHYS-1:0] latch_en;

  vsr_step_gen #(.NUM_PHYS(NUM_PHYS), .MAX_VIRT(MAX_VIRT), .PASS_W(PASS_W)) i_step (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .virt_count(virt_count), .passes(passes),
    .iss_valid(iss_valid), .iss_v(iss_v), .iss_p(iss_p), .iss_virt(iss_virt),
    .iss_first(iss_first), .iss_save(iss_save), .iss_last(iss_last), .nv_o(nv)
  );

  assign cfg_rd_en   = iss_valid;
  assign cfg_rd_addr = iss_v;
  assign st_rd_en    = iss_valid && iss_virt && !iss_first;
  assign st_rd_addr  = iss_v;

  vsr_apply #(.NUM_PHYS(NUM_PHYS), .MAX_VIRT(MAX_VIRT), .R0_W(R0_W)) i_apply (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_v(iss_v), .iss_p(iss_p), .iss_virt(iss_virt),
    .iss_first(iss_first), .iss_save(iss_save), .iss_last(iss_last), .nv(nv),
    .st_rd_en(st_rd_en), .st_rd_data(st_rd_data), .init_r0(init_r0),
    .r0_save(r0_save), .latch_en(latch_en), .r0_restore(r0_restore),
    .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .init_idx(init_idx), .ap_valid(ap_valid), .done(done)
  );

  assign stripe_cfg    = cfg_rd_data;
  assign stripe_cfg_en = latch_en;
  assign r0_restore_en = latch_en;
  assign busy          = iss_valid || ap_valid;

  p_cfg_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |=> (stripe_cfg_en != '0));

  p_ring_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stripe_cfg_en != '0) && ($past(stripe_cfg_en) != '0)) |->
      (stripe_cfg_en == {$past(stripe_cfg_en[NUM_PHYS-2:0]), $past(stripe_cfg_en[NUM_PHYS-1])}));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/test_vsr_sequencer.sv
module test_vsr_sequencer;
  localparam int NP = 4, MV = 16, CW = 672, RW = 8, PW = 4;
  localparam int VA_W = 4, VC_W = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VC_W-1:0] virt_count = '0;
  logic [PW-1:0]   passes = '0;
  logic busy, done, cfg_rd_en, st_rd_en, st_wr_en;
  logic [VA_W-1:0] cfg_rd_addr, st_rd_addr, st_wr_addr, init_idx;
  logic [CW-1:0]   cfg_rd_data = '0, stripe_cfg;
  logic [NP-1:0]   stripe_cfg_en, r0_restore_en;
  logic [RW-1:0]   st_rd_data = '0, st_wr_data, init_r0, r0_restore;
  logic [NP*RW-1:0] r0_save;

  always #10 clk = ~clk;

  vsr_sequencer #(.NUM_PHYS(NP), .MAX_VIRT(MV), .CFG_W(CW), .R0_W(RW), .PASS_W(PW)) i_vsr_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .virt_count(virt_count), .passes(passes),
    .busy(busy), .done(done), .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .stripe_cfg(stripe_cfg), .stripe_cfg_en(stripe_cfg_en),
    .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data),
    .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .init_idx(init_idx), .init_r0(init_r0), .r0_save(r0_save),
    .r0_restore(r0_restore), .r0_restore_en(r0_restore_en)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cfg_word(input int v);
    logic [CW-1:0] w;
    for (int i = 0; i < CW / 32; i++) w[i*32 +: 32] = 32'hC0DE0000 + 32'(v * 256 + i);
    return w;
  endfunction

  function automatic logic [RW-1:0] init_val(input int v);
    return RW'(8'hA0 ^ v);
  endfunction

  // Memory and fabric models
  logic [RW-1:0] st_mem [MV];
  logic [RW-1:0] fab [NP];
  initial for (int i = 0; i < MV; i++) st_mem[i] = '0;

  always @(posedge clk) begin
    if (cfg_rd_en) cfg_rd_data <= cfg_word(int'(cfg_rd_addr));
    if (st_rd_en)  st_rd_data  <= st_mem[st_rd_addr];
    if (st_wr_en)  st_mem[st_wr_addr] <= st_wr_data;
  end

  assign init_r0 = init_val(int'(init_idx));

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (!rst_n)                fab[p] <= RW'(p * 16);
      else if (r0_restore_en[p]) fab[p] <= r0_restore;
      else                       fab[p] <= fab[p] + RW'(p + 1);
    end
  end

  always_comb for (int p = 0; p < NP; p++) r0_save[p*RW +: RW] = fab[p];

  // Scoreboard
  typedef struct {
    int p; int v; bit save; int save_addr; bit first; bit fwd;
  } item_t;
  item_t exp_q[$];
  logic [RW-1:0] exp_vstate [MV];
  int rd_count = 0;
  bit prev_rd_en = 0;
  int prev_rd_addr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (st_rd_en) rd_count++;
      if (stripe_cfg_en != '0) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected load", 64'(stripe_cfg_en), 0);
        end else begin
          item_t it;
          logic [RW-1:0] er;
          it = exp_q.pop_front();
          chk(stripe_cfg_en == NP'(1 << it.p), "R2 R4 latch enable stripe", 64'(stripe_cfg_en), 64'(1 << it.p));
          chk(r0_restore_en == stripe_cfg_en, "R3 restore enable", 64'(r0_restore_en), 64'(stripe_cfg_en));
          chk(prev_rd_en && prev_rd_addr == it.v, "R2 read issued one cycle before", 64'(prev_rd_addr), 64'(it.v));
          chk(stripe_cfg == cfg_word(it.v), "R2 config word", stripe_cfg[63:0], cfg_word(it.v)[63:0]);
          chk(st_wr_en == it.save, "R5 save enable", 64'(st_wr_en), 64'(it.save));
          if (it.save && st_wr_en) begin
            chk(int'(st_wr_addr) == it.save_addr, "R5 save address", 64'(st_wr_addr), 64'(it.save_addr));
            chk(st_wr_data == fab[it.p], "R5 save data", 64'(st_wr_data), 64'(fab[it.p]));
            exp_vstate[it.save_addr] = fab[it.p];
          end
          if (it.first) begin
            er = init_val(it.v);
            chk(r0_restore == er, "R6 initial restore", 64'(r0_restore), 64'(er));
          end else begin
            er = exp_vstate[it.v];
            if (it.fwd) chk(r0_restore == er, "R8 forwarded restore", 64'(r0_restore), 64'(er));
            else        chk(r0_restore == er, "R7 stored restore", 64'(r0_restore), 64'(er));
          end
        end
      end else if (st_wr_en) begin
        chk(0, "R5 write without load", 64'(st_wr_addr), 0);
      end
      prev_rd_en   = cfg_rd_en;
      prev_rd_addr = int'(cfg_rd_addr);
    end
  end

  // Driver: push expected loads, start the run, time the end pulse
  task automatic run(input int nv, input int ps, input bit poke);
    int pe, steps, n;
    bit virt;
    virt  = nv > NP;
    pe    = (ps == 0) ? 1 : ps;
    steps = virt ? nv * pe : nv;
    for (int k = 0; k < steps; k++) begin
      item_t it;
      it.v = k % nv; it.p = k % NP;
      it.first = (k < nv);
      it.save = virt && (k >= NP);
      it.save_addr = it.save ? (k - NP) % nv : 0;
      it.fwd = (nv == NP + 1) && !it.first;
      exp_q.push_back(it);
    end
    rd_count = 0;
    @(negedge clk);
    start = 1; virt_count = VC_W'(nv); passes = PW'(ps);
    @(negedge clk);
    start = 0; n = 1;
    chk(busy == 1'b1, "R9 busy after start", 64'(busy), 1);
    while (!done && n < steps + 10) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin start = 1; virt_count = 5'd2; end
      else start = 0;
    end
    start = 0;
    chk(n == steps + 2, "R9 done cycle", 64'(n), 64'(steps + 2));
    chk(busy == 1'b0, "R9 idle at done", 64'(busy), 0);
    chk(exp_q.size() == 0, "R2 all loads seen", 64'(exp_q.size()), 0);
    chk(rd_count == (virt ? nv * (pe - 1) : 0), "R6 R7 state reads", 64'(rd_count), 64'(virt ? nv * (pe - 1) : 0));
    @(negedge clk);
    chk(done == 1'b0, "R9 done is a pulse", 64'(done), 0);
  endtask

  task automatic try_bad(input int nv);
    @(negedge clk);
    start = 1; virt_count = VC_W'(nv); passes = 4'd2;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !cfg_rd_en, "R1 bad count ignored", 64'({busy, cfg_rd_en}), 0);
      @(negedge clk);
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, cfg_rd_en, st_rd_en, st_wr_en} == '0 && stripe_cfg_en == '0,
        "R10 reset state", 64'({busy, done, cfg_rd_en, st_rd_en, st_wr_en, stripe_cfg_en}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R10 idle after reset", 64'({busy, done}), 0);
    run(7, 3, 0);   // virtualized, read and write far apart
    run(5, 3, 0);   // nv = NUM_PHYS+1: same-cycle forward, R8
    run(3, 5, 0);   // fits: passes ignored, no save or restore
    run(4, 2, 0);   // boundary nv = NUM_PHYS
    run(16, 2, 1);  // largest design; start while busy is ignored (R1)
    run(6, 0, 0);   // passes of 0 counts as one (R1)
    try_bad(0);
    try_bad(17);
    run(9, 2, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule